// File: doc/BRIEF.md
# Clock Frequency Auto-Range Detector

This block works out which of three operating bands an incoming bus clock falls in, so that a PLL can be given the matching range setting. It runs in the domain of a reference oscillator whose frequency is known. Over a fixed number of reference cycles it counts how often the bus clock's activity indicator changes. It then compares that count against two thresholds and reports a two-bit range code.

A three-bit configuration word is captured while reset is held. That word does one of two things. It can force a range outright, with no measurement. Or it can start an automatic measurement and name which of three reference frequencies (19.44, 25 or 32 MHz) is fitted. One automatic variant measures without ever asking for a PLL reset. The result and the done flag are settled once per reset and hold until the next reset. During an automatic measurement the block keeps a PLL-reset request raised until the result is known.

Top module: `fdet_autorange`

## Requirements
- R1: Configuration codes 001, 010 and 011 report range codes 00, 01 and 10 respectively. For these codes the done flag is high in the first reference cycle after reset release, and the PLL-reset request stays low.
- R2: Configuration code 000 reports range code 00 with the done flag high in the first reference cycle after reset release, with no measurement.
- R3: Codes 110 and 111 measure against a 25 MHz and a 32 MHz reference respectively. They use windows of WIN1 and WIN2 reference cycles.
- R4: Codes 100 and 101 measure against a 19.44 MHz reference using a window of WIN0 reference cycles. In every automatic mode, a bus clock below 25 MHz gives code 00, 25 to 35 MHz gives 01, and 35 MHz or above (up to 66 MHz) gives 10.
- R5: If the bus clock is stopped, or counts fewer than MIN_COUNT changes in the window, the result is code 00 and done is still raised.
- R6: In codes 100, 110 and 111, the PLL-reset request is high from the first reference cycle after reset release. It falls in the same cycle that done rises.
- R7: In code 101 the PLL-reset request is never raised.
- R8: Once done is high, done and the range code hold their values until the next reset. Changes to the configuration input after reset release have no effect.
- R9: While reset is low, done is 0, the range code is 00 and the PLL-reset request is 0.
- R10: The range code 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Known-frequency reference oscillator; all outputs are in this domain |
| meas_clk | input | 1 | Bus clock under measurement, 0 to 66 MHz, asynchronous to ref_clk |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg | input | 3 | Mode word: forced range, reserved shortcut, or automatic with reference choice |
| range_code | output | 2 | 00 below 25 MHz, 01 for 25 to 35 MHz, 10 for 35 MHz and above |
| done | output | 1 | High once the range code is valid |
| pll_rst_req | output | 1 | Request to hold the PLL in reset while measuring |

## Verification
The bench builds the block with a prescaler of 8, with the 19.44 MHz window left at 3888 reference cycles, with the 25 and 32 MHz windows shortened to 160 and 256 cycles, and with a minimum count of 4. The thresholds then become 625/875, 20/28 and 25/35 edges. The short windows finish in a few hundred cycles. This puts a sweep within reach that covers every configuration code, a stopped clock, 66 MHz, and frequencies just below and just above both band boundaries for each reference. The bench picks test frequencies that keep each expected count at least one edge clear of a threshold, so the single-edge uncertainty of the synchronizer cannot flip a result.

// File: rtl/fdet_pkg.sv
// Package: shared types and configuration decode for the auto-range detector.
// Assumes the three-bit configuration word is stable while reset is held.
package fdet_pkg;

    typedef enum logic [1:0] {
        RANGE_LOW  = 2'b00,
        RANGE_MID  = 2'b01,
        RANGE_HIGH = 2'b10
    } range_e;

    typedef enum logic [1:0] {
        ST_INIT,
        ST_SETTLE,
        ST_COUNT,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic       auto_en;    // run a measurement
        logic       pll_rst_en; // raise the PLL-reset request while measuring
        logic [1:0] ref_sel;    // which reference frequency is fitted
        range_e     forced;     // result when no measurement runs
    } mode_t;

    // Turn the configuration word into the mode fields used by the controller.
    function automatic mode_t decode_mode(input logic [2:0] code);
        mode_t m;
        m = '{auto_en: 1'b0, pll_rst_en: 1'b0, ref_sel: 2'd0, forced: RANGE_LOW};
        case (code)
            3'b001: m.forced = RANGE_LOW;
            3'b010: m.forced = RANGE_MID;
            3'b011: m.forced = RANGE_HIGH;
            3'b100: begin m.auto_en = 1'b1; m.pll_rst_en = 1'b1; m.ref_sel = 2'd0; end
            3'b101: begin m.auto_en = 1'b1; m.pll_rst_en = 1'b0; m.ref_sel = 2'd0; end
            3'b110: begin m.auto_en = 1'b1; m.pll_rst_en = 1'b1; m.ref_sel = 2'd1; end
            3'b111: begin m.auto_en = 1'b1; m.pll_rst_en = 1'b1; m.ref_sel = 2'd2; end
            default: m.forced = RANGE_LOW;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fdet_meas_toggle.sv
// Measured-domain prescaler: flips a level once every DIV rising edges of the
// bus clock, so the level changes slowly enough to be sampled in the
// reference domain. Assumes DIV is a power of two of at least 2, and that reset
// is held across a few bus-clock edges. A stopped bus clock just freezes the level.
module fdet_meas_toggle #(
    parameter int DIV = 8
) (
    input  logic meas_clk,
    input  logic rst_n,
    output logic tog
);
    localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;

    logic [DIV_W-1:0] div_cnt;

    // Count bus-clock edges and flip the level on each wrap.
    always_ff @(posedge meas_clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            tog     <= 1'b0;
        end else if (div_cnt == DIV_W'(DIV - 1)) begin
            div_cnt <= '0;
            tog     <= ~tog;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fdet_edge_sync.sv
// Reference-domain synchronizer and change detector. It passes the asynchronous
// toggle level through STAGES flops, then pulses for one cycle on either
// direction of change. Assumes the toggle holds each level for more than one
// reference period.
module fdet_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_async,
    output logic edge_pulse
);
    logic [STAGES-1:0] sq;
    logic              prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop samples the asynchronous level.
            always_ff @(posedge clk) begin
                if (!rst_n) sq[0] <= 1'b0;
                else        sq[0] <= tog_async;
            end
        end else begin : g_rest
            // Later flops resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) sq[i] <= 1'b0;
                else        sq[i] <= sq[i-1];
            end
        end
    end

    // Remember the last synchronized level for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sq[STAGES-1];
    end

    assign edge_pulse = sq[STAGES-1] ^ prev_q;

endmodule

// File: rtl/fdet_window_ctrl.sv
// Measurement controller in the reference domain. After reset it either loads
// a forced range at once, or it waits SETTLE cycles, counts change pulses over
// the window chosen by the mode, and classifies the count against two
// thresholds. Assumes the mode is constant after reset release. The result is
// loaded exactly once per reset.
module fdet_window_ctrl
    import fdet_pkg::*;
#(
    parameter int DIV       = 8,
    parameter int WIN0      = 3888,
    parameter int WIN1      = 320,
    parameter int WIN2      = 512,
    parameter int REF0_10K  = 1944,
    parameter int REF1_10K  = 2500,
    parameter int REF2_10K  = 3200,
    parameter int LO_10K    = 2500,
    parameter int HI_10K    = 3500,
    parameter int MIN_COUNT = 8,
    parameter int SETTLE    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  mode_t      mode,
    input  logic       edge_pulse,
    output logic [1:0] range_o,
    output logic       done_o,
    output logic       req_o
);
    localparam int WIN_MAX = (WIN0 > WIN1) ? ((WIN0 > WIN2) ? WIN0 : WIN2)
                                           : ((WIN1 > WIN2) ? WIN1 : WIN2);
    localparam int CNT_W   = $clog2(WIN_MAX + 1);
    localparam int SET_W   = (SETTLE > 1) ? $clog2(SETTLE) : 1;

    localparam logic [CNT_W-1:0] THR_LO0 = CNT_W'(LO_10K * WIN0 / (REF0_10K * DIV));
    localparam logic [CNT_W-1:0] THR_HI0 = CNT_W'(HI_10K * WIN0 / (REF0_10K * DIV));
    localparam logic [CNT_W-1:0] THR_LO1 = CNT_W'(LO_10K * WIN1 / (REF1_10K * DIV));
    localparam logic [CNT_W-1:0] THR_HI1 = CNT_W'(HI_10K * WIN1 / (REF1_10K * DIV));
    localparam logic [CNT_W-1:0] THR_LO2 = CNT_W'(LO_10K * WIN2 / (REF2_10K * DIV));
    localparam logic [CNT_W-1:0] THR_HI2 = CNT_W'(HI_10K * WIN2 / (REF2_10K * DIV));
    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_COUNT);

    state_e           state_q, state_d;
    logic [SET_W-1:0] settle_cnt;
    logic [CNT_W-1:0] win_cnt, edge_cnt;
    logic [CNT_W-1:0] win_len, thr_lo, thr_hi;
    range_e           range_q, measured;
    logic             done_q, req_q;

    // Pick window length and thresholds for the fitted reference.
    always_comb begin
        case (mode.ref_sel)
            2'd1:    begin win_len = CNT_W'(WIN1); thr_lo = THR_LO1; thr_hi = THR_HI1; end
            2'd2:    begin win_len = CNT_W'(WIN2); thr_lo = THR_LO2; thr_hi = THR_HI2; end
            default: begin win_len = CNT_W'(WIN0); thr_lo = THR_LO0; thr_hi = THR_HI0; end
        endcase
    end

    // Classify the edge count; a near-silent clock falls back to the low band.
    always_comb begin
        if (edge_cnt < MIN_CNT)     measured = RANGE_LOW;
        else if (edge_cnt < thr_lo) measured = RANGE_LOW;
        else if (edge_cnt < thr_hi) measured = RANGE_MID;
        else                        measured = RANGE_HIGH;
    end

    // Next-state logic of the measurement sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_INIT:   state_d = mode.auto_en ? ST_SETTLE : ST_DONE;
            ST_SETTLE: if (settle_cnt == SET_W'(SETTLE - 1)) state_d = ST_COUNT;
            ST_COUNT:  if (win_cnt == win_len - 1'b1)        state_d = ST_DONE;
            default:   state_d = ST_DONE;
        endcase
    end

    // State, counters and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_INIT;
            settle_cnt <= '0;
            win_cnt    <= '0;
            edge_cnt   <= '0;
            range_q    <= RANGE_LOW;
            done_q     <= 1'b0;
            req_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SETTLE) settle_cnt <= settle_cnt + 1'b1;
            if (state_q == ST_COUNT) begin
                win_cnt <= win_cnt + 1'b1;
                if (edge_pulse) edge_cnt <= edge_cnt + 1'b1;
            end
            if (state_d == ST_DONE && state_q != ST_DONE)
                range_q <= (state_q == ST_INIT) ? mode.forced : measured;
            done_q <= (state_d == ST_DONE);
            req_q  <= mode.auto_en && mode.pll_rst_en &&
                      (state_d == ST_SETTLE || state_d == ST_COUNT);
        end
    end

    assign range_o = range_q;
    assign done_o  = done_q;
    assign req_o   = req_q;

endmodule

// File: rtl/fdet_autorange.sv
// Top of the clock auto-range detector. It captures the configuration word
// while reset is low, prescales the bus clock in its own domain, carries the
// toggle into the reference domain and runs the window controller there.
// Assumes rst_n is synchronous to ref_clk and is held for several cycles of both clocks.
module fdet_autorange
    import fdet_pkg::*;
#(
    parameter int DIV       = 8,
    parameter int WIN0      = 3888,
    parameter int WIN1      = 320,
    parameter int WIN2      = 512,
    parameter int MIN_COUNT = 8,
    parameter int SETTLE    = 4,
    parameter int STAGES    = 2
) (
    input  logic       ref_clk,
    input  logic       meas_clk,
    input  logic       rst_n,
    input  logic [2:0] cfg,
    output logic [1:0] range_code,
    output logic       done,
    output logic       pll_rst_req
);
    logic [2:0] cfg_q;
    logic       tog;
    logic       edge_pulse;
    mode_t      mode;

    // Hold the configuration word as seen during reset.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) cfg_q <= cfg;
    end

    assign mode = decode_mode(cfg_q);

    fdet_meas_toggle #(.DIV(DIV)) u_tog (
        .meas_clk (meas_clk),
        .rst_n    (rst_n),
        .tog      (tog)
    );

    fdet_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .tog_async  (tog),
        .edge_pulse (edge_pulse)
    );

    fdet_window_ctrl #(
        .DIV       (DIV),
        .WIN0      (WIN0),
        .WIN1      (WIN1),
        .WIN2      (WIN2),
        .REF0_10K  (1944),
        .REF1_10K  (2500),
        .REF2_10K  (3200),
        .LO_10K    (2500),
        .HI_10K    (3500),
        .MIN_COUNT (MIN_COUNT),
        .SETTLE    (SETTLE)
    ) u_ctrl (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .edge_pulse (edge_pulse),
        .range_o    (range_code),
        .done_o     (done),
        .req_o      (pll_rst_req)
    );

endmodule

// File: rtl/fdet_autorange_chk.sv
// Checker for the auto-range detector: temporal rules on done, the range code
// and the PLL-reset request. Attached to every instance of the top by bind.
module fdet_autorange_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cfg_q,
    input logic [1:0] range_code,
    input logic       done,
    input logic       pll_rst_req
);
    assert_forced_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[2] |=> done);

    assert_forced_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[2] |-> !pll_rst_req);

    assert_req_rises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && cfg_q[2] && cfg_q != 3'b101) |=> pll_rst_req);

    assert_req_falls_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_rst_req) |-> done);

    assert_req_done_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pll_rst_req && done));

    assert_no_req_quiet_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == 3'b101) |-> !pll_rst_req);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_range_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(range_code));

    assert_no_code_11_R10: assert property (@(posedge clk) disable iff (!rst_n)
        range_code != 2'b11);

endmodule

bind fdet_autorange fdet_autorange_chk u_chk (
    .clk         (ref_clk),
    .rst_n       (rst_n),
    .cfg_q       (cfg_q),
    .range_code  (range_code),
    .done        (done),
    .pll_rst_req (pll_rst_req)
);

// File: tb/fdet_autorange_tb.sv
`timescale 1ns/1ps
module fdet_autorange_tb;
    localparam int DIV  = 8;
    localparam int WIN0 = 3888;
    localparam int WIN1 = 160;
    localparam int WIN2 = 256;

    logic       ref_clk = 1'b0;
    logic       meas_clk;
    logic       rst_n = 1'b0;
    logic [2:0] cfg = 3'b000;
    logic [1:0] range_code;
    logic       done;
    logic       pll_rst_req;
    real        meas_half = 0.0;
    int         checks = 0;
    int         fails = 0;
    bit         finished = 1'b0;

    fdet_autorange #(
        .DIV(DIV), .WIN0(WIN0), .WIN1(WIN1), .WIN2(WIN2),
        .MIN_COUNT(4), .SETTLE(4), .STAGES(2)
    ) u_dut (
        .ref_clk     (ref_clk),
        .meas_clk    (meas_clk),
        .rst_n       (rst_n),
        .cfg         (cfg),
        .range_code  (range_code),
        .done        (done),
        .pll_rst_req (pll_rst_req)
    );

    // 50 MHz reference clock; its period stands for the fitted reference.
    always #10 ref_clk = ~ref_clk;

    // Bus clock with a programmable half period; zero means stopped.
    initial begin
        meas_clk = 1'b0;
        forever begin
            if (meas_half > 0.0) begin
                #(meas_half) meas_clk = ~meas_clk;
            end else begin
                #(10.0);
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge ref_clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int band(input int f_mhz);
        if (f_mhz < 25)      return 0;
        else if (f_mhz < 35) return 1;
        else                 return 2;
    endfunction

    function automatic real ref_mhz(input logic [2:0] c);
        if (c == 3'b110)      return 25.0;
        else if (c == 3'b111) return 32.0;
        else                  return 19.44;
    endfunction

    // One reset-and-measure cycle for a configuration and bus frequency.
    task automatic run_case(input logic [2:0] c, input int f_mhz);
        bit    autom, need, bad;
        int    n, exp;
        string tag;
        cfg = c;
        meas_half = (f_mhz == 0) ? 0.0 : 10.0 * ref_mhz(c) / real'(f_mhz);
        @(negedge ref_clk);
        rst_n = 1'b0;
        repeat (4) @(negedge ref_clk);
        // R9: reset state
        chk(done == 1'b0 && range_code == 2'b00 && pll_rst_req == 1'b0, "R9",
            {29'd0, done, range_code}, 0);
        rst_n = 1'b1;
        @(negedge ref_clk);
        autom = c[2];
        need  = autom && (c != 3'b101);
        if (!autom) begin
            chk(done == 1'b1, (c == 3'b000) ? "R2" : "R1", int'(done), 1);
        end else begin
            chk(pll_rst_req == need, need ? "R6" : "R7", int'(pll_rst_req), int'(need));
            bad = 1'b0;
            n = 0;
            while (!done && n < 9000) begin
                if (pll_rst_req != need) bad = 1'b1;
                @(negedge ref_clk);
                n++;
            end
            chk(done == 1'b1, "R3", int'(done), 1);
            chk(!bad, need ? "R6" : "R7", int'(bad), 0);
        end
        exp = !autom ? ((c == 3'b011) ? 2 : (c == 3'b010) ? 1 : 0)
                     : ((f_mhz == 0) ? 0 : band(f_mhz));
        tag = !autom ? ((c == 3'b000) ? "R2" : "R1")
                     : (f_mhz == 0) ? "R5" : c[1] ? "R3" : "R4";
        chk(range_code == exp[1:0], tag, int'(range_code), exp);
        chk(pll_rst_req == 1'b0, "R6", int'(pll_rst_req), 0);
        chk(range_code != 2'b11, "R10", int'(range_code), 0);
        // R8: later configuration and clock changes are ignored
        cfg = ~c;
        meas_half = 7.3;
        repeat (40) @(negedge ref_clk);
        chk(done == 1'b1 && range_code == exp[1:0], "R8", int'(range_code), exp);
    endtask

    initial begin
        int freqs[6] = '{15, 22, 27, 33, 38, 60};
        repeat (3) @(negedge ref_clk);
        // R1 and R2: forced and reserved codes
        run_case(3'b001, 30);
        run_case(3'b010, 10);
        run_case(3'b011, 20);
        run_case(3'b000, 50);
        // R4 and R5: 19.44 MHz reference, including stopped and fastest clocks
        run_case(3'b100, 0);
        foreach (freqs[i]) run_case(3'b100, freqs[i]);
        run_case(3'b100, 66);
        // R7: quiet variant
        run_case(3'b101, 15);
        run_case(3'b101, 30);
        run_case(3'b101, 60);
        // R3: 25 MHz and 32 MHz references
        foreach (freqs[i]) run_case(3'b110, freqs[i]);
        foreach (freqs[i]) run_case(3'b111, freqs[i]);
        run_case(3'b111, 0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule